// File: doc/BRIEF.md
# Supply Level Request Controller

This block asks an external regulator for a new core supply level and confirms that the level was reached. Software or a sequencer writes a target level with an apply bit set. The controller folds the level into the code the regulator understands and drives that code on a request output, with a one-cycle strobe. It then waits a settle interval. The interval is held in a register in microseconds and is turned into core clock cycles by a cycles-per-microsecond parameter.

When the interval has run out, the controller compares the level reported back by the regulator with the code it requested. It emits a one-cycle done pulse when they match and a one-cycle error pulse when they do not. An error also sets a sticky status bit. Software clears that bit by writing a one to it. A small register port gives write access to the request, status and settle registers and combinational read access to all three.

Top module: `supply_lvl_ctrl`

## Requirements
- R1: After reset the request output is code 0, busy, done, error and the strobe are low, the sticky error bit is 0, and the settle register holds its reset value (2 µs by default).
- R2: A write to address 0 with bit 7 set, while idle, starts a request: after that clock edge busy is high, the request output carries the new code and the strobe is high for exactly one cycle. A write to address 0 with bit 7 clear starts nothing.
- R3: The target level is taken from write bits 5:3. Levels 3, 4, 5 and 6 are all driven as code 3. Levels 0, 1, 2 and 7 are driven unchanged. The request output never shows 4, 5 or 6.
- R4: With S the settle register value and C the cycles-per-microsecond parameter, the result pulse appears exactly S*C+1 cycles after the starting edge. Busy stays high until that edge and falls together with the pulse.
- R5: At the end of the wait, done pulses if the reported level equals the requested code, and error pulses otherwise. Exactly one of the two fires, for one cycle.
- R6: A write with bit 7 set while busy is ignored: the request code, the strobe and the result timing are unchanged.
- R7: The status register at address 1 holds the sticky error in bit 0. It is set by every error pulse and cleared by writing 1 to bit 0. Writing 0 leaves it unchanged, and a new error wins over a clear in the same cycle.
- R8: Reads are combinational. Address 0 returns {busy, 0, requested code[2:0], reported level[2:0]}. Address 1 returns {000000, busy, sticky error}. Address 2 returns the settle value in microseconds, which is written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| lvl_req | output | 3 | Requested level code to the regulator |
| lvl_req_stb | output | 1 | One-cycle pulse when a new code is issued |
| lvl_stat | input | 3 | Level reported by the regulator |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: level confirmed |
| err | output | 1 | One-cycle pulse: level mismatch |

## Verification
Inputs are driven on falling edges and outputs are sampled on the following falling edges. Sample k therefore shows the state after the k-th rising edge counted from the apply write. The strobe, busy and new code are due at sample 1. Busy with no result is expected through sample S*C+1, the single result pulse at sample S*C+2, and quiet outputs one sample later. The sticky bit is read a few cycles after the pulse, and register reads are checked 1 ns after the address changes. The regulator model echoes the request after a fixed delay and can corrupt it. The bench therefore predicts whether the compare sees the echoed or the previous code, and from that whether done or error is due.

// File: rtl/supply_lvl_pkg.sv
package supply_lvl_pkg;

    localparam int LVL_W  = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_SETTLE = 2'd2;

    // control word fields (decoded by the regulator side convention)
    localparam int APPLY_BIT  = 7;
    localparam int LVL_LSB    = 3;
    localparam int STICKY_BIT = 0;

    localparam logic [LVL_W-1:0] SHARED_CODE = 3'd3;

    typedef enum logic {
        ST_IDLE,
        ST_SETTLE
    } seq_state_t;

    typedef struct packed {
        logic             apply;
        logic [LVL_W-1:0] level;
    } lvl_cmd_t;

    // levels 3..6 map onto one voltage code
    function automatic logic [LVL_W-1:0] fold_level(input logic [LVL_W-1:0] lv);
        if (lv >= 3'd3 && lv <= 3'd6)
            return SHARED_CODE;
        return lv;
    endfunction

endpackage

// File: rtl/supply_lvl_regs.sv
module supply_lvl_regs
    import supply_lvl_pkg::*;
#(
    parameter int SETTLE_W        = 8,
    parameter int RESET_SETTLE_US = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 busy,
    input  logic                 err_pulse,
    input  logic [LVL_W-1:0]     req_code,
    input  logic [LVL_W-1:0]     lvl_stat,
    output lvl_cmd_t             cmd,
    output logic [SETTLE_W-1:0]  settle_us,
    output logic                 sticky_err
);

    logic sticky_clr;

    always_comb begin
        cmd.apply  = wr_en && (wr_addr == A_CTRL) && wr_data[APPLY_BIT];
        cmd.level  = wr_data[LVL_LSB +: LVL_W];
        sticky_clr = wr_en && (wr_addr == A_STAT) && wr_data[STICKY_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_us  <= SETTLE_W'(RESET_SETTLE_US);
            sticky_err <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_SETTLE)
                settle_us <= wr_data[SETTLE_W-1:0];
            if (err_pulse)
                sticky_err <= 1'b1;
            else if (sticky_clr)
                sticky_err <= 1'b0;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = {busy, 1'b0, req_code, lvl_stat};
            A_STAT:   rd_data = {6'b0, busy, sticky_err};
            A_SETTLE: rd_data = DATA_W'(settle_us);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/supply_lvl_timer.sv
module supply_lvl_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/supply_lvl_fsm.sv
module supply_lvl_fsm
    import supply_lvl_pkg::*;
#(
    parameter logic [LVL_W-1:0] RESET_LVL = 3'd0
) (
    input  logic             clk,
    input  logic             rst,
    input  lvl_cmd_t         cmd,
    input  logic [LVL_W-1:0] lvl_stat,
    input  logic             expired,
    output logic             timer_load,
    output logic             timer_run,
    output logic [LVL_W-1:0] lvl_req,
    output logic             lvl_req_stb,
    output logic             busy,
    output logic             done,
    output logic             err
);

    seq_state_t state_q;

    assign timer_load = (state_q == ST_IDLE) && cmd.apply;
    assign timer_run  = (state_q == ST_SETTLE);
    assign busy       = (state_q == ST_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lvl_req     <= RESET_LVL;
            lvl_req_stb <= 1'b0;
            done        <= 1'b0;
            err         <= 1'b0;
        end else begin
            lvl_req_stb <= 1'b0;
            done        <= 1'b0;
            err         <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd.apply) begin
                        lvl_req     <= fold_level(cmd.level);
                        lvl_req_stb <= 1'b1;
                        state_q     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (expired) begin
                        state_q <= ST_IDLE;
                        if (lvl_stat == lvl_req)
                            done <= 1'b1;
                        else
                            err <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/supply_lvl_ctrl.sv
module supply_lvl_ctrl
    import supply_lvl_pkg::*;
#(
    parameter int               CYC_PER_US      = 4,
    parameter int               SETTLE_W        = 8,
    parameter int               RESET_SETTLE_US = 2,
    parameter logic [LVL_W-1:0] RESET_LVL       = 3'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic [2:0]        lvl_req,
    output logic              lvl_req_stb,
    input  logic [2:0]        lvl_stat,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int CNT_W = SETTLE_W + $clog2(CYC_PER_US + 1);

    lvl_cmd_t            cmd;
    logic [SETTLE_W-1:0] settle_us;
    logic                sticky_err;
    logic                timer_load;
    logic                timer_run;
    logic                expired;
    logic [CNT_W-1:0]    settle_cycles;

    assign settle_cycles = CNT_W'(settle_us) * CNT_W'(CYC_PER_US);

    supply_lvl_regs #(
        .SETTLE_W       (SETTLE_W),
        .RESET_SETTLE_US(RESET_SETTLE_US)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .err_pulse (err),
        .req_code  (lvl_req),
        .lvl_stat  (lvl_stat),
        .cmd       (cmd),
        .settle_us (settle_us),
        .sticky_err(sticky_err)
    );

    supply_lvl_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(settle_cycles),
        .run     (timer_run),
        .expired (expired)
    );

    supply_lvl_fsm #(
        .RESET_LVL(RESET_LVL)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .lvl_stat   (lvl_stat),
        .expired    (expired),
        .timer_load (timer_load),
        .timer_run  (timer_run),
        .lvl_req    (lvl_req),
        .lvl_req_stb(lvl_req_stb),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

endmodule

// File: rtl/supply_lvl_checker.sv
module supply_lvl_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [2:0] lvl_req,
    input logic       lvl_req_stb,
    input logic       sticky_err
);

    // R5: one result per request, never both
    a_r5_result_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R5: result pulses last one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r5_err_single: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    // R4: busy ends exactly with a result pulse
    a_r4_busy_ends_with_result: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || err));
    a_r4_result_not_busy: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);

    // R2: strobe only marks the start of a busy period
    a_r2_stb_in_busy: assert property (@(posedge clk) disable iff (rst)
        lvl_req_stb |-> (busy && $rose(busy)));

    // R6: request code held for the whole busy period
    a_r6_code_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lvl_req));

    // R3: folded range never appears on the request
    a_r3_no_folded_code: assert property (@(posedge clk) disable iff (rst)
        !(lvl_req inside {3'd4, 3'd5, 3'd6}));

    // R7: an error always leaves the sticky bit set
    a_r7_sticky_set: assert property (@(posedge clk) disable iff (rst)
        err |=> sticky_err);

endmodule

bind supply_lvl_ctrl supply_lvl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .lvl_req    (lvl_req),
    .lvl_req_stb(lvl_req_stb),
    .sticky_err (sticky_err)
);

// File: tb/supply_lvl_ctrl_bench.sv
`timescale 1ns/1ps
module supply_lvl_ctrl_bench;

    localparam int CPU    = 4;
    localparam int ECHO_D = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [2:0] lvl_req;
    logic       lvl_req_stb;
    logic [2:0] lvl_stat;
    logic       busy, done, err;

    int n_tests = 0;
    int n_fail  = 0;

    logic [2:0] model_code = 3'd0;
    bit         sticky_m   = 1'b0;
    bit         fault      = 1'b0;
    logic [2:0] pipe [ECHO_D];

    always #2.5 clk = ~clk;

    supply_lvl_ctrl #(.CYC_PER_US(CPU)) u_supply_lvl_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lvl_req(lvl_req),
        .lvl_req_stb(lvl_req_stb), .lvl_stat(lvl_stat), .busy(busy),
        .done(done), .err(err)
    );

    // regulator model: delayed echo, optionally corrupted
    initial for (int i = 0; i < ECHO_D; i++) pipe[i] = 3'd0;
    always @(posedge clk) begin
        pipe[0] <= lvl_req;
        for (int i = 1; i < ECHO_D; i++) pipe[i] <= pipe[i-1];
    end
    assign lvl_stat = fault ? (pipe[ECHO_D-1] ^ 3'b001) : pipe[ECHO_D-1];

    function automatic logic [2:0] fold(input logic [2:0] lv);
        return (lv >= 3 && lv <= 6) ? 3'd3 : lv;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_settle(input int us);
        wr(2'd2, 8'(us));
        rd_addr = 2'd2; #1;
        chk(rd_data == 8'(us), "R8 settle readback", rd_data, us);
    endtask

    task automatic do_request(input logic [2:0] lvl, input int n_cyc,
                              input bit flt, input bit inject);
        logic [2:0] code;
        logic [2:0] seen;
        bit         exp_ok;
        code   = fold(lvl);
        seen   = (n_cyc >= ECHO_D) ? code : model_code;
        if (flt) seen = seen ^ 3'b001;
        exp_ok = (seen == code);
        fault  = flt;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = {1'b1, 1'b0, lvl, 3'b000};
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy && lvl_req_stb, "R2 start", {busy, lvl_req_stb}, 3);
        chk(lvl_req == code, "R3 code", lvl_req, code);
        for (int s = 2; s <= n_cyc + 2; s++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (s <= n_cyc + 1) begin
                chk(busy && !done && !err, "R4 waiting", {busy, done, err}, 4);
                chk(lvl_req == code && !lvl_req_stb, "R6 held", lvl_req, code);
            end else begin
                chk(done == exp_ok && err == !exp_ok && !busy, "R5 result",
                    {busy, done, err}, {1'b0, exp_ok, !exp_ok});
            end
            if (inject && s == 2) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = {1'b1, 1'b0, ~lvl, 3'b000};
            end
        end
        @(negedge clk);
        chk(!done && !err, "R5 single pulse", {done, err}, 0);
        if (!exp_ok) sticky_m = 1'b1;
        model_code = code;
        repeat (ECHO_D + 1) @(negedge clk);
        fault = 1'b0;
        rd_addr = 2'd0; #1;
        chk(rd_data == {2'b00, code, code}, "R8 ctrl read", rd_data, {2'b00, code, code});
        rd_addr = 2'd1; #1;
        chk(rd_data == {7'b0, sticky_m}, "R7 sticky", rd_data, sticky_m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(lvl_req == 3'd0 && !busy && !done && !err && !lvl_req_stb, "R1 outputs",
            {lvl_req, busy, done, err, lvl_req_stb}, 0);
        rd_addr = 2'd1; #1;
        chk(rd_data == 8'd0, "R1 status", rd_data, 0);
        rd_addr = 2'd2; #1;
        chk(rd_data == 8'd2, "R1 settle reset", rd_data, 2);

        // R2 write without apply bit: nothing starts
        wr(2'd0, {1'b0, 1'b0, 3'd5, 3'b000});
        chk(!busy && !lvl_req_stb && lvl_req == 3'd0, "R2 no apply",
            {busy, lvl_req_stb, lvl_req}, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err, "R2 no apply idle", {busy, done, err}, 0);

        // default settle 2us -> 8 cycles
        do_request(3'd7, 2 * CPU, 1'b0, 1'b0);
        do_request(3'd4, 2 * CPU, 1'b0, 1'b0);   // R3 fold to 3
        do_request(3'd6, 2 * CPU, 1'b0, 1'b0);   // R3 same code again
        do_request(3'd2, 2 * CPU, 1'b0, 1'b1);   // R6 apply while busy

        // R4 zero settle: compare before echo -> error
        set_settle(0);
        do_request(3'd1, 0, 1'b0, 1'b0);
        // R7 write 0 keeps sticky, write 1 clears
        wr(2'd1, 8'h00);
        rd_addr = 2'd1; #1;
        chk(rd_data[0] == 1'b1, "R7 write0 keeps", rd_data[0], 1);
        wr(2'd1, 8'h01); sticky_m = 1'b0;
        rd_addr = 2'd1; #1;
        chk(rd_data[0] == 1'b0, "R7 write1 clears", rd_data[0], 0);

        // R5 corrupted echo
        set_settle(1);
        do_request(3'd5, CPU, 1'b1, 1'b0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int us;
            us = $urandom_range(0, 4);
            set_settle(us);
            do_request(3'($urandom_range(0, 7)), us * CPU,
                       ($urandom_range(0, 4) == 0), (us >= 1) && ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 2) == 0) begin
                wr(2'd1, 8'h01); sticky_m = 1'b0;
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule